// File: doc/BRIEF.md
# Pin-Controlled Power-Down Hold Unit

This wrapper sits between a logic core and the external pins. A static option bit decides whether two dedicated power-down pins are active. When the option is set and either pin is high, the wrapper freezes everything the outside world can observe. The input values seen by the core stay at their last valid levels. Clock ticks to the core are suppressed. The output data and output-enable values at the pins keep their last values, so an output that was floating when the freeze began stays floating. Normal operation resumes on the first clock edge after both pins are low again.

When the option is cleared, the power-down pins are ordinary logic inputs, and their values reach the core through the same registered path as the other inputs. When the option is set, the core sees those two pins as constant low. The wrapper has registered outputs throughout. Every path from an input to an output has one cycle of latency.

Top module: `pd_hold_wrap`

## Requirements
- R1: With `opt_pd_en` low, the power-down pins never cause a hold. `core_pd_pins` equals `pd_pins` one clock edge later, and `pd_active` stays low.
- R2: With `opt_pd_en` high, a hold request exists in any cycle in which at least one bit of `pd_pins` is high. `pd_active` is high after each edge that samples a request and low after each edge that does not.
- R3: On an edge that samples a hold request, `pad_out` and `pad_oe` keep their previous values, whatever `core_out_data` and `core_out_oe` do.
- R4: A `pad_oe` bit that was 0 (high impedance) when the hold began remains 0 for the whole hold interval.
- R5: On an edge that samples a hold request, `core_in` keeps its previous value, whatever `pin_in` does.
- R6: On an edge with no hold request, `core_in`, `pad_out` and `pad_oe` take the values of `pin_in`, `core_out_data` and `core_out_oe`. This includes the first edge after both power-down pins return low.
- R7: `core_tick` is `ext_tick` delayed by one edge. It is forced low on every edge that samples a hold request, including the edge on which the hold begins.
- R8: With `opt_pd_en` high, `core_pd_pins` is all zeros after each edge.
- R9: A synchronous active-high `rst` clears `core_in`, `core_tick`, `core_pd_pins`, `pad_out`, `pad_oe` and `pd_active` to 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| opt_pd_en | input | 1 | Static option: enables the power-down function |
| pd_pins | input | N_PD | Power-down pins, ORed together |
| pin_in | input | N_IN | External input pins |
| ext_tick | input | 1 | External clock-tick request for the core |
| core_out_data | input | N_OUT | Output data from the core |
| core_out_oe | input | N_OUT | Output enables from the core |
| core_in | output | N_IN | Input values presented to the core |
| core_tick | output | 1 | Gated clock tick to the core |
| core_pd_pins | output | N_PD | Power-down pins as logic inputs to the core |
| pad_out | output | N_OUT | Output data driven toward the pins |
| pad_oe | output | N_OUT | Output enables toward the pins (0 = high impedance) |
| pd_active | output | 1 | High while a power-down hold is in effect |

## Verification
The stimulus table applies each power-down pin on its own, then both together, then neither. This shows that the pins behave as an OR and that release needs both pins low. During holds, the table drives inputs and core outputs that differ from the frozen values, and it enables outputs that were floating. This separates a real hold from a design that lets changes through. Rows with the option cleared pass the same pin patterns, which confirms that the pins then act only as data. Directed tests cover a hold lasting several cycles against a changing input bus, and a reset issued while a hold request is present.

// File: rtl/pdh_pkg.sv
package pdh_pkg;
  typedef enum logic {
    PDH_RUN  = 1'b0,
    PDH_HOLD = 1'b1
  } pdh_mode_e;
endpackage

// File: rtl/pdh_detect.sv
module pdh_detect #(
  parameter int N_PD = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            opt_pd_en,
  input  logic [N_PD-1:0] pd_pins,
  output logic            hold_req,
  output logic            pd_active,
  output logic [N_PD-1:0] core_pd_pins
);
  import pdh_pkg::*;

  pdh_mode_e mode_q;

  // any pin high requests the hold, only when the option is set
  assign hold_req = opt_pd_en & (|pd_pins);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= PDH_RUN;
    else     mode_q <= hold_req ? PDH_HOLD : PDH_RUN;
  end

  assign pd_active = (mode_q == PDH_HOLD);

  // with the option set the pins are reserved and read as zero by the core
  for (genvar i = 0; i < N_PD; i++) begin : g_pdpin
    always_ff @(posedge clk) begin
      if (rst) core_pd_pins[i] <= 1'b0;
      else     core_pd_pins[i] <= pd_pins[i] & ~opt_pd_en;
    end
  end
endmodule

// File: rtl/pdh_hold_reg.sv
module pdh_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (!hold) q <= d;
  end
endmodule

// File: rtl/pdh_tick_gate.sv
module pdh_tick_gate (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic tick_in,
  output logic tick_out
);
  // a tick arriving together with the hold request is dropped
  always_ff @(posedge clk) begin
    if (rst) tick_out <= 1'b0;
    else     tick_out <= tick_in & ~hold;
  end
endmodule

// File: rtl/pd_hold_wrap.sv
module pd_hold_wrap #(
  parameter int N_PD  = 2,
  parameter int N_IN  = 8,
  parameter int N_OUT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             opt_pd_en,
  input  logic [N_PD-1:0]  pd_pins,
  input  logic [N_IN-1:0]  pin_in,
  input  logic             ext_tick,
  input  logic [N_OUT-1:0] core_out_data,
  input  logic [N_OUT-1:0] core_out_oe,
  output logic [N_IN-1:0]  core_in,
  output logic             core_tick,
  output logic [N_PD-1:0]  core_pd_pins,
  output logic [N_OUT-1:0] pad_out,
  output logic [N_OUT-1:0] pad_oe,
  output logic             pd_active
);
  localparam int W_PAD = 2 * N_OUT;

  logic             hold_req;
  logic [W_PAD-1:0] pad_d;
  logic [W_PAD-1:0] pad_q;

  pdh_detect #(.N_PD(N_PD)) u_detect (
    .clk          (clk),
    .rst          (rst),
    .opt_pd_en    (opt_pd_en),
    .pd_pins      (pd_pins),
    .hold_req     (hold_req),
    .pd_active    (pd_active),
    .core_pd_pins (core_pd_pins)
  );

  pdh_hold_reg #(.W(N_IN)) u_in_hold (
    .clk  (clk),
    .rst  (rst),
    .hold (hold_req),
    .d    (pin_in),
    .q    (core_in)
  );

  // data and enables are frozen together, so a floating pin stays floating
  assign pad_d = {core_out_oe, core_out_data};

  pdh_hold_reg #(.W(W_PAD)) u_pad_hold (
    .clk  (clk),
    .rst  (rst),
    .hold (hold_req),
    .d    (pad_d),
    .q    (pad_q)
  );

  assign pad_out = pad_q[N_OUT-1:0];
  assign pad_oe  = pad_q[W_PAD-1:N_OUT];

  pdh_tick_gate u_tick (
    .clk      (clk),
    .rst      (rst),
    .hold     (hold_req),
    .tick_in  (ext_tick),
    .tick_out (core_tick)
  );
endmodule

// File: rtl/pd_hold_wrap_chk.sv
module pd_hold_wrap_chk #(
  parameter int N_PD  = 2,
  parameter int N_IN  = 8,
  parameter int N_OUT = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             opt_pd_en,
  input logic [N_PD-1:0]  pd_pins,
  input logic [N_IN-1:0]  pin_in,
  input logic [N_OUT-1:0] core_out_data,
  input logic [N_OUT-1:0] core_out_oe,
  input logic [N_IN-1:0]  core_in,
  input logic             core_tick,
  input logic [N_PD-1:0]  core_pd_pins,
  input logic [N_OUT-1:0] pad_out,
  input logic [N_OUT-1:0] pad_oe,
  input logic             pd_active
);
  logic req;
  assign req = opt_pd_en && (|pd_pins);

  AST_OPT_OFF_NO_HOLD: assert property (@(posedge clk) disable iff (rst)
    !opt_pd_en |=> !pd_active); // R1
  AST_REQ_SETS_STATUS: assert property (@(posedge clk) disable iff (rst)
    req |=> pd_active); // R2
  AST_PAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    req |=> ($stable(pad_out) && $stable(pad_oe))); // R3
  AST_HIZ_KEPT: assert property (@(posedge clk) disable iff (rst)
    (req && (pad_oe == '0)) |=> (pad_oe == '0)); // R4
  AST_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    req |=> $stable(core_in)); // R5
  AST_RUN_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !req |=> (core_in == $past(pin_in) && pad_out == $past(core_out_data)
              && pad_oe == $past(core_out_oe))); // R6
  AST_TICK_BLOCK: assert property (@(posedge clk) disable iff (rst)
    req |=> !core_tick); // R7
  AST_PDPIN_MASK: assert property (@(posedge clk) disable iff (rst)
    opt_pd_en |=> (core_pd_pins == '0)); // R8
endmodule

bind pd_hold_wrap pd_hold_wrap_chk #(.N_PD(N_PD), .N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .opt_pd_en     (opt_pd_en),
  .pd_pins       (pd_pins),
  .pin_in        (pin_in),
  .core_out_data (core_out_data),
  .core_out_oe   (core_out_oe),
  .core_in       (core_in),
  .core_tick     (core_tick),
  .core_pd_pins  (core_pd_pins),
  .pad_out       (pad_out),
  .pad_oe        (pad_oe),
  .pd_active     (pd_active)
);

// File: tb/pd_hold_wrap_tb_top.sv
module pd_hold_wrap_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       opt_pd_en = 1'b0;
  logic [1:0] pd_pins = '0;
  logic [7:0] pin_in = '0;
  logic       ext_tick = 1'b0;
  logic [3:0] core_out_data = '0;
  logic [3:0] core_out_oe = '0;
  logic [7:0] core_in;
  logic       core_tick;
  logic [1:0] core_pd_pins;
  logic [3:0] pad_out;
  logic [3:0] pad_oe;
  logic       pd_active;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pd_hold_wrap #(.N_PD(2), .N_IN(8), .N_OUT(4)) dut_i (
    .clk           (clk),
    .rst           (rst),
    .opt_pd_en     (opt_pd_en),
    .pd_pins       (pd_pins),
    .pin_in        (pin_in),
    .ext_tick      (ext_tick),
    .core_out_data (core_out_data),
    .core_out_oe   (core_out_oe),
    .core_in       (core_in),
    .core_tick     (core_tick),
    .core_pd_pins  (core_pd_pins),
    .pad_out       (pad_out),
    .pad_oe        (pad_oe),
    .pd_active     (pd_active)
  );

  // stimulus {opt, pd[1:0], tick, pin_in[7:0], odata[3:0], ooe[3:0]}
  // expected {core_in[7:0], pad_out[3:0], pad_oe[3:0], tick, pd_active, core_pd[1:0]}
  localparam int NV = 10;
  localparam logic [39:0] VEC [NV] = '{
    40'h9A59F_A59F8,  // R6 R7 run, tick passes
    40'h83C63_3C630,  // R6 run
    40'hBFFFF_3C634,  // R2 R3 R5 R7 entry on pin 0, tick dropped
    40'hD000C_3C634,  // R2 R4 pin 1 alone, floating outputs stay floating
    40'hE115F_3C634,  // R3 R5 both pins
    40'h977AC_77AC8,  // R6 release
    40'h78135_8135B,  // R1 option off, pins as data
    40'h442C0_42C02,  // R1
    40'hC9911_42C04,  // R4 R8 all floating held
    40'h89911_99110   // R6 release
  };

  function automatic string vtag(int i);
    case (i)
      0: return "R6/R7";
      1: return "R6";
      2: return "R2/R3/R5/R7";
      3: return "R2/R4";
      4: return "R3/R5";
      5: return "R6";
      6, 7: return "R1";
      8: return "R4/R8";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [19:0] observed();
    return {core_in, pad_out, pad_oe, core_tick, pd_active, core_pd_pins};
  endfunction

  task automatic check(string tag, logic [19:0] act, logic [19:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] frozen;
    repeat (2) @(negedge clk);
    check("R9 reset state", observed(), 20'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      {opt_pd_en, pd_pins, ext_tick, pin_in, core_out_data, core_out_oe} = VEC[i][39:20];
      @(negedge clk);
      check(vtag(i), observed(), VEC[i][19:0]);
    end

    // R5: long hold against a changing input bus
    frozen = core_in;
    opt_pd_en = 1'b1;
    pd_pins = 2'b01;
    for (int k = 0; k < 5; k++) begin
      pin_in = 8'(8'h10 + k * 8'h13);
      ext_tick = 1'b1;
      @(negedge clk);
      check("R5 long hold core_in", {12'h0, core_in}, {12'h0, frozen});
      check("R7 tick blocked in hold", {19'h0, core_tick}, 20'h0);
    end
    pd_pins = 2'b00;
    pin_in = 8'h5A;
    @(negedge clk);
    check("R6 release core_in", {12'h0, core_in}, {12'h0, 8'h5A});
    check("R2 status drops", {19'h0, pd_active}, 20'h0);

    // R9: reset while a hold request is present
    pd_pins = 2'b11;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R9 reset during hold", observed(), 20'h0);
    rst = 1'b0;
    opt_pd_en = 1'b0;
    pd_pins = 2'b01;
    @(negedge clk);
    check("R1 pins reach core when option off", {18'h0, core_pd_pins}, 20'h1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule